// File: doc/BRIEF.md
# Operand Data Address Generator

This block forms the operand addresses for a DSP-style core. For single-operand instructions it drives a 16-bit data-memory address built in one of three ways. Direct addressing joins a 9-bit page pointer with the low 7 bits of the instruction. Page-zero addressing replaces the page bits with zeros, so low-page registers can be reached without touching the page pointer. Indirect addressing passes through the full value of one of eight auxiliary registers.

For two-address block moves, the block runs a small sequencer. The incoming program counter is parked in a holding register. The source pointer is then loaded from either the second instruction word or a block-address register, and it drives the program-bus operand address. For a repeat count N, the source pointer and the destination data address each step by one per transfer, for N+1 transfers. After the last transfer, the parked program counter is returned on `pc_o` together with a one-cycle completion pulse.

Top module: `opnd_addr_gen`

## Requirements
- R1: With `mode_i` = 2'b00 and `instr_i[7]` = 0, `dma_o` equals `{page_i, instr_i[6:0]}` in the same cycle.
- R2: With `mode_i` = 2'b00 and `instr_i[7]` = 1, `dma_o` equals auxiliary register `arp_i`, which is bits [16*k+15:16*k] of `ar_flat_i` for k = `arp_i`.
- R3: With `mode_i` = 2'b01, `dma_o[15:7]` is zero and `dma_o[6:0]` equals `instr_i[6:0]`. `instr_i[7]` and `page_i` have no effect.
- R4: While no move is running (`busy_o` = 0 and `done_o` = 0), `pab_o` and `pc_o` both follow `pc_i`.
- R5: A `start_i` sampled while idle with `mode_i` = 2'b10 sets `busy_o` in the next cycle. In that cycle `pab_o` and `pc_o` equal the `word2_i` value that was present at the start edge.
- R6: A start with `mode_i` = 2'b11 behaves like R5, except that the first `pab_o` is the `bmar_i` value taken at the start edge.
- R7: A repeat count N, taken at the start edge, gives exactly N+1 consecutive `busy_o` cycles. `pab_o` rises by one per cycle and wraps modulo 2^16.
- R8: During a move, `dma_o` starts at `{page_i, instr_i[6:0]}` taken at the start edge and rises by one per transfer, wrapping modulo 2^16.
- R9: In the cycle after the last transfer, `done_o` is high for exactly one cycle. In that cycle `pc_o` equals the `pc_i` value taken at the start edge, whatever `pc_i` has done since. The block is idle in the following cycle.
- R10: `start_i` is ignored while `busy_o` or `done_o` is high, and also when `mode_i` is 2'b00 or 2'b01.
- R11: While `rst_ni` is low, the block is idle with `busy_o` = 0, `done_o` = 0 and all internal registers at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 normal, 01 page-zero, 10 move from second word, 11 move from block register |
| start_i | input | 1 | Begin a block move (block modes only) |
| instr_i | input | 16 | Instruction word |
| page_i | input | 9 | Page pointer |
| arp_i | input | 3 | Auxiliary register selector |
| ar_flat_i | input | 128 | Eight 16-bit auxiliary registers, register k at bits 16k+15:16k |
| bmar_i | input | 16 | Block-address register |
| pc_i | input | 16 | Current program counter |
| word2_i | input | 16 | Second instruction word |
| rpt_cnt_i | input | 16 | Repeat count N (N+1 transfers) |
| dma_o | output | 16 | Data-memory operand address |
| pab_o | output | 16 | Program-bus operand address |
| pc_o | output | 16 | Program counter value |
| busy_o | output | 1 | A transfer takes place this cycle |
| done_o | output | 1 | Move complete, program counter restored |

## Verification
A wrong source or destination pointer appears at `pab_o` or `dma_o` in the very first transfer cycle, one edge after the start. An increment fault appears in the second transfer cycle. A wrong repeat counter only shows when the move ends: `busy_o` falls one cycle early or late. A corrupted holding register stays hidden for the whole move and only appears at `pc_o` in the single `done_o` cycle. For that reason the bench changes `pc_i` in the middle of a move and checks the restored value against the one taken at the start.

// File: rtl/oag_pkg.sv
package oag_pkg;
  typedef enum logic [1:0] {
    MODE_NORM     = 2'b00,
    MODE_PAGE0    = 2'b01,
    MODE_BLK_WORD = 2'b10,
    MODE_BLK_REG  = 2'b11
  } oag_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_MOVE    = 2'b01,
    ST_RESTORE = 2'b10
  } oag_state_e;
endpackage

// File: rtl/oag_ar_sel.sv
module oag_ar_sel #(
  parameter int NUM_AR = 8,
  parameter int ADDR_W = 16,
  localparam int SEL_W = $clog2(NUM_AR)
) (
  input  logic [NUM_AR*ADDR_W-1:0] ar_flat_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic [ADDR_W-1:0]        ar_o
);
  logic [ADDR_W-1:0] ar_arr [NUM_AR];

  for (genvar k = 0; k < NUM_AR; k++) begin : g_unpack
    assign ar_arr[k] = ar_flat_i[k*ADDR_W +: ADDR_W];
  end

  assign ar_o = ar_arr[sel_i];
endmodule

// File: rtl/oag_data_addr.sv
module oag_data_addr
  import oag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 9,
  localparam int OFS_W = ADDR_W - PAGE_W
) (
  input  oag_mode_e           mode_i,
  input  logic [ADDR_W-1:0]   instr_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic [ADDR_W-1:0]   ar_val_i,
  output logic [ADDR_W-1:0]   addr_o
);
  localparam int IND_BIT = OFS_W;

  logic [OFS_W-1:0] ofs;
  assign ofs = instr_i[OFS_W-1:0];

  always_comb begin
    unique case (mode_i)
      MODE_PAGE0: addr_o = {{PAGE_W{1'b0}}, ofs};
      MODE_NORM:  addr_o = instr_i[IND_BIT] ? ar_val_i : {page_i, ofs};
      default:    addr_o = {page_i, ofs};
    endcase
  end
endmodule

// File: rtl/oag_blk_seq.sv
module oag_blk_seq
  import oag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  oag_mode_e         mode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] word2_i,
  input  logic [ADDR_W-1:0] bmar_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [ADDR_W-1:0] hold_o
);
  oag_state_e        state_q, state_d;
  logic [ADDR_W-1:0] src_q, dst_q, hold_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              blk_mode, accept, last;

  assign blk_mode = (mode_i == MODE_BLK_WORD) || (mode_i == MODE_BLK_REG);
  assign accept   = (state_q == ST_IDLE) && start_i && blk_mode;
  assign last     = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_MOVE;
      ST_MOVE:    if (last)   state_d = ST_RESTORE;
      ST_RESTORE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      hold_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        hold_q <= pc_i;
        src_q  <= (mode_i == MODE_BLK_REG) ? bmar_i : word2_i;
        dst_q  <= dst_i;
        cnt_q  <= cnt_i;
      end else if ((state_q == ST_MOVE) && !last) begin
        src_q <= src_q + 1'b1;
        dst_q <= dst_q + 1'b1;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = (state_q == ST_MOVE);
  assign done_o = (state_q == ST_RESTORE);
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import oag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 9,
  parameter int NUM_AR = 8,
  parameter int CNT_W  = 16,
  localparam int SEL_W = $clog2(NUM_AR)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        instr_i,
  input  logic [PAGE_W-1:0]        page_i,
  input  logic [SEL_W-1:0]         arp_i,
  input  logic [NUM_AR*ADDR_W-1:0] ar_flat_i,
  input  logic [ADDR_W-1:0]        bmar_i,
  input  logic [ADDR_W-1:0]        pc_i,
  input  logic [ADDR_W-1:0]        word2_i,
  input  logic [CNT_W-1:0]         rpt_cnt_i,
  output logic [ADDR_W-1:0]        dma_o,
  output logic [ADDR_W-1:0]        pab_o,
  output logic [ADDR_W-1:0]        pc_o,
  output logic                     busy_o,
  output logic                     done_o
);
  oag_mode_e         mode;
  logic [ADDR_W-1:0] ar_val, base_addr, src, dst, hold;

  assign mode = oag_mode_e'(mode_i);

  oag_ar_sel #(.NUM_AR(NUM_AR), .ADDR_W(ADDR_W)) u_ar_sel (
    .ar_flat_i (ar_flat_i),
    .sel_i     (arp_i),
    .ar_o      (ar_val)
  );

  oag_data_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_data_addr (
    .mode_i   (mode),
    .instr_i  (instr_i),
    .page_i   (page_i),
    .ar_val_i (ar_val),
    .addr_o   (base_addr)
  );

  oag_blk_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_blk_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mode_i  (mode),
    .pc_i    (pc_i),
    .word2_i (word2_i),
    .bmar_i  (bmar_i),
    .dst_i   (base_addr),
    .cnt_i   (rpt_cnt_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .src_o   (src),
    .dst_o   (dst),
    .hold_o  (hold)
  );

  // PC is the source pointer during a move, restored value on completion
  always_comb begin
    if (busy_o) begin
      dma_o = dst;
      pab_o = src;
      pc_o  = src;
    end else if (done_o) begin
      dma_o = base_addr;
      pab_o = hold;
      pc_o  = hold;
    end else begin
      dma_o = base_addr;
      pab_o = pc_i;
      pc_o  = pc_i;
    end
  end
endmodule

// File: rtl/oag_chk.sv
module oag_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] dma_o,
  input logic [ADDR_W-1:0] pab_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int OFS_W = ADDR_W - PAGE_W;

  // R7
  pab_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> pab_o == $past(pab_o) + {{(ADDR_W-1){1'b0}}, 1'b1});

  // R8
  dma_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> dma_o == $past(dma_o) + {{(ADDR_W-1){1'b0}}, 1'b1});

  // R9
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));

  // R9
  done_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o);

  // R4
  idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !done_o |-> pab_o == pc_i && pc_o == pc_i);

  // R3
  page0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && mode_i == 2'b01 |-> dma_o[ADDR_W-1:OFS_W] == '0);

  // R10
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, done_o}));
endmodule

bind opnd_addr_gen oag_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mode_i (mode_i),
  .pc_i   (pc_i),
  .dma_o  (dma_o),
  .pab_o  (pab_o),
  .pc_o   (pc_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/opnd_addr_gen_tb.sv
`timescale 1ns/100ps
module opnd_addr_gen_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         start = 1'b0;
  logic [15:0]  instr = '0;
  logic [8:0]   page = '0;
  logic [2:0]   arp = '0;
  logic [127:0] ar_flat;
  logic [15:0]  bmar = '0, pc = '0, word2 = '0, rpt = '0;
  logic [15:0]  dma, pab, pc_out;
  logic         busy, done;
  int           n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  opnd_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .start_i(start),
    .instr_i(instr), .page_i(page), .arp_i(arp), .ar_flat_i(ar_flat),
    .bmar_i(bmar), .pc_i(pc), .word2_i(word2), .rpt_cnt_i(rpt),
    .dma_o(dma), .pab_o(pab), .pc_o(pc_out), .busy_o(busy), .done_o(done)
  );

  // register k = 0xA000 ^ (k * 0x1111)
  initial for (int k = 0; k < 8; k++) ar_flat[k*16 +: 16] = 16'hA000 ^ (16'(k) * 16'h1111);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // {mode, instr, page, arp, expected dma}
  localparam logic [45:0] VEC [0:7] = '{
    {2'b00, 16'h0010, 9'h003, 3'd0, 16'h0190},  // R1
    {2'b00, 16'hA07F, 9'h1FF, 3'd0, 16'hFFFF},  // R1
    {2'b00, 16'h0000, 9'h100, 3'd5, 16'h8000},  // R1
    {2'b00, 16'h0085, 9'h0AA, 3'd3, 16'h9333},  // R2
    {2'b00, 16'h0080, 9'h000, 3'd7, 16'hD777},  // R2
    {2'b00, 16'hFF80, 9'h1FF, 3'd0, 16'hA000},  // R2
    {2'b01, 16'h0007, 9'h1FF, 3'd2, 16'h0007},  // R3
    {2'b01, 16'h00FF, 9'h155, 3'd6, 16'h007F}   // R3
  };

  task automatic blk_move(input string tag, input logic [1:0] md, input logic [15:0] exp_src,
                          input logic [15:0] n, input logic [15:0] exp_dst,
                          input logic [15:0] pc_save, input bit disturb);
    @(negedge clk);
    mode = md; pc = pc_save; rpt = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= int'(n); k++) begin
      #1;
      chk({tag, " R7 busy"}, 16'(busy), 16'd1);
      chk({tag, " R5/R6/R7 pab"}, pab, exp_src + 16'(k));
      chk({tag, " R5 pc_o"}, pc_out, exp_src + 16'(k));
      chk({tag, " R8 dma"}, dma, exp_dst + 16'(k));
      if (disturb && k == 0) begin
        start = 1'b1; word2 = 16'hDEAD; bmar = 16'hBEEF; pc = 16'h7777; rpt = 16'd50;
      end
      @(negedge clk);
    end
    start = 1'b0;
    #1;
    chk({tag, " R9 done"}, 16'(done), 16'd1);
    chk({tag, " R7 busy end"}, 16'(busy), 16'd0);
    chk({tag, " R9 pc restore"}, pc_out, pc_save);
    @(negedge clk);
    #1;
    chk({tag, " R9 idle done"}, 16'(done), 16'd0);
    chk({tag, " R10 idle busy"}, 16'(busy), 16'd0);
    chk({tag, " R4 idle pab"}, pab, pc);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    pc = 16'h1234;
    #7;
    // R11 reset state
    chk("R11 busy", 16'(busy), 16'd0);
    chk("R11 done", 16'(done), 16'd0);
    chk("R11 pc_o", pc_out, 16'h1234);
    @(negedge clk); rst_n = 1'b1;

    foreach (VEC[i]) begin
      @(negedge clk);
      {mode, instr, page, arp} = VEC[i][45:16];
      #1;
      chk($sformatf("R1/R2/R3 vec %0d dma", i), dma, VEC[i][15:0]);
      chk($sformatf("R4 vec %0d pab", i), pab, pc);
    end

    // R10 start in non-block modes ignored
    @(negedge clk); mode = 2'b00; start = 1'b1; pc = 16'h0400;
    @(negedge clk); mode = 2'b01;
    @(negedge clk); start = 1'b0; #1;
    chk("R10 no start busy", 16'(busy), 16'd0);
    chk("R4 pc_o follow", pc_out, 16'h0400);

    // R5 move from second word, N=3, dest {0x012, 0x05}
    page = 9'h012; instr = 16'h0005; word2 = 16'h1230;
    blk_move("long", 2'b10, 16'h1230, 16'd3, 16'h0905, 16'h4000, 1'b0);

    // R6 R7 R8 register source with wrap, N=1
    page = 9'h1FF; instr = 16'h007F; bmar = 16'hFFFF; word2 = 16'h5555;
    blk_move("reg wrap", 2'b11, 16'hFFFF, 16'd1, 16'hFFFF, 16'h0222, 1'b0);

    // R7 single transfer
    page = 9'h001; instr = 16'h0000; bmar = 16'h0300;
    blk_move("reg N0", 2'b11, 16'h0300, 16'd0, 16'h0080, 16'h0333, 1'b0);

    // R10 R9 start and pc changes mid-move ignored
    page = 9'h002; instr = 16'h0011; word2 = 16'h2000;
    blk_move("disturb", 2'b10, 16'h2000, 16'd2, 16'h0111, 16'h4444, 1'b1);

    // R11 async reset mid-move
    @(negedge clk); mode = 2'b10; word2 = 16'h0100; rpt = 16'd20; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R11 reset busy", 16'(busy), 16'd0);
    chk("R11 reset pab", pab, pc);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R11 after reset busy", 16'(busy), 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule